// File: doc/BRIEF.md
# Bounded Slower/Faster Event Merger

This block watches two event streams, `evA` and `evB`, each a single-cycle pulse sampled on the system clock. It produces two derived event streams. `slowTick` follows whichever input has so far produced fewer events. `fastTick` follows whichever input has produced more. When both inputs have produced the same number of events, `fastTick` fires on any input event, and `slowTick` fires only when both inputs fire in the same cycle. Taken together, the slower output counts the minimum of the two occurrence counts and the faster output counts the maximum.

The block does not keep two unbounded counters. It keeps a single signed lead value, equal to the count of A minus the count of B. This value is limited to the range -BOUND to +BOUND, which gives 2·BOUND+1 states. An input event that would push the lead past either limit is refused: the lead stays at the limit, and a sticky `overflow` flag is raised. The two outputs are combinational. They are decoded from the lead value registered before the current cycle, together with the current inputs.

Top module: `tick_bound_merge`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, the lead is zero and `overflow` is 0.
- R2: At each clock edge, the lead rises by one when only `evA` is high, falls by one when only `evB` is high, and stays unchanged when both or neither are high.
- R3: While the registered lead is positive, `slowTick` equals `evB` and `fastTick` equals `evA` in the same cycle.
- R4: While the registered lead is negative, `slowTick` equals `evA` and `fastTick` equals `evB` in the same cycle.
- R5: While the registered lead is zero, `fastTick` equals `evA | evB` and `slowTick` equals `evA & evB` in the same cycle.
- R6: An `evA`-only cycle at lead +BOUND, or an `evB`-only cycle at lead -BOUND, leaves the lead at that limit and sets `overflow` from the next cycle on.
- R7: Once set, `overflow` stays 1 until `rstN` is driven low.
- R8: The outputs respond without delay. They are decided by the lead before the current edge, so a cycle that changes the lead uses the old value for its own outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| evA | input | 1 | First event input |
| evB | input | 1 | Second event input |
| slowTick | output | 1 | Event stream of the input with fewer occurrences |
| fastTick | output | 1 | Event stream of the input with more occurrences |
| overflow | output | 1 | Sticky flag: the lead hit a limit and an event was refused |

## Verification
The hardest situation to create is the refusal at a limit. It requires BOUND more one-sided events than the other side has produced, with no event on the other side in between. The refused event must then be followed by traffic that shows the lead held at the limit instead of wrapping. The stimulus drives long one-sided bursts in both directions, with a reset between them. It then runs a mixed random phase that returns to the limits repeatedly. A behavioural reference built from two clamped occurrence counters is compared with all three outputs in every cycle.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic clip;
  } tbm_strobe_t;
endpackage

// File: rtl/tbm_datapath.sv
module tbm_datapath
  import tbm_pkg::*;
#(
  parameter int BOUND = 4,
  parameter int DW    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  tbm_strobe_t strb,
  output logic        diffPos,
  output logic        diffNeg,
  output logic        atTop,
  output logic        atBottom,
  output logic        ovfFlag
);
  localparam logic signed [DW-1:0] TOP = DW'(BOUND);
  localparam logic signed [DW-1:0] BOT = -DW'(BOUND);

  logic signed [DW-1:0] lead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lead    <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (strb.stepUp)        lead <= lead + DW'(1);
      else if (strb.stepDown) lead <= lead - DW'(1);
      if (strb.clip)          ovfFlag <= 1'b1;
    end
  end

  assign diffPos  = (lead > 0);
  assign diffNeg  = (lead < 0);
  assign atTop    = (lead == TOP);
  assign atBottom = (lead == BOT);

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepUp |=> (lead == $past(lead) + DW'(1)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.stepUp && !strb.stepDown) |=> $stable(lead));
  a_r6_limit: assert property (@(posedge clk) disable iff (!rstN)
    (lead <= TOP) && (lead >= BOT));
  a_r6_clip_sets: assert property (@(posedge clk) disable iff (!rstN)
    strb.clip |=> ovfFlag);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);
endmodule

// File: rtl/tbm_ctrl.sv
module tbm_ctrl
  import tbm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evA,
  input  logic        evB,
  input  logic        diffPos,
  input  logic        diffNeg,
  input  logic        atTop,
  input  logic        atBottom,
  output tbm_strobe_t strb,
  output logic        slowTick,
  output logic        fastTick
);
  logic aOnly, bOnly;

  always_comb begin
    aOnly         = evA && !evB;
    bOnly         = evB && !evA;
    strb.stepUp   = aOnly && !atTop;
    strb.stepDown = bOnly && !atBottom;
    strb.clip     = (aOnly && atTop) || (bOnly && atBottom);
    if (diffPos) begin
      slowTick = evB;
      fastTick = evA;
    end else if (diffNeg) begin
      slowTick = evA;
      fastTick = evB;
    end else begin
      slowTick = evA && evB;
      fastTick = evA || evB;
    end
  end

  a_r2_one_dir: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.stepUp && strb.stepDown));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!evA && !evB) |-> (!slowTick && !fastTick));
  a_r5_both_both: assert property (@(posedge clk) disable iff (!rstN)
    (evA && evB) |-> (slowTick && fastTick));
endmodule

// File: rtl/tick_bound_merge.sv
module tick_bound_merge
  import tbm_pkg::*;
#(
  parameter int BOUND = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic evA,
  input  logic evB,
  output logic slowTick,
  output logic fastTick,
  output logic overflow
);
  localparam int DW = $clog2(BOUND + 1) + 1;

  tbm_strobe_t strb;
  logic diffPos, diffNeg, atTop, atBottom;

  tbm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .evA(evA), .evB(evB),
    .diffPos(diffPos), .diffNeg(diffNeg), .atTop(atTop), .atBottom(atBottom),
    .strb(strb), .slowTick(slowTick), .fastTick(fastTick)
  );

  tbm_datapath #(.BOUND(BOUND), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .diffPos(diffPos), .diffNeg(diffNeg), .atTop(atTop), .atBottom(atBottom),
    .ovfFlag(overflow)
  );
endmodule

// File: tb/tb_tick_bound_merge.sv
module tb_tick_bound_merge;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evA = 1'b0, evB = 1'b0;
  logic slowTick, fastTick, overflow;
  int checks = 0, failures = 0;
  int cntA = 0, cntB = 0;
  bit refOvf = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tick_bound_merge #(.BOUND(N)) dut (
    .clk(clk), .rstN(rstN), .evA(evA), .evB(evB),
    .slowTick(slowTick), .fastTick(fastTick), .overflow(overflow)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare outputs, update reference at posedge
  task automatic step(input logic a, input logic b);
    int lead;
    logic expSlow, expFast;
    @(negedge clk);
    evA = a; evB = b;
    #1;
    lead = cntA - cntB;
    if (lead > 0) begin
      expSlow = b; expFast = a;
      check("R3 R8 slow", slowTick, expSlow); check("R3 fast", fastTick, expFast);
    end else if (lead < 0) begin
      expSlow = a; expFast = b;
      check("R4 R8 slow", slowTick, expSlow); check("R4 fast", fastTick, expFast);
    end else begin
      expSlow = a & b; expFast = a | b;
      check("R5 R2 slow", slowTick, expSlow); check("R5 fast", fastTick, expFast);
    end
    check("R7 overflow", overflow, refOvf);
    @(posedge clk);
    if (a) cntA++;
    if (b) cntB++;
    if (cntA - cntB > N) begin cntA--; refOvf = 1; end
    if (cntB - cntA > N) begin cntB--; refOvf = 1; end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; evA = 0; evB = 0;
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R1 overflow in reset", overflow, 1'b0);
    check("R1 fast in reset", fastTick, 1'b0);
    rstN = 1;
    cntA = 0; cntB = 0; refOvf = 0;
  endtask

  initial begin
    doReset();
    // R1: zero lead right after reset -> equal-count behaviour
    step(1, 0);
    step(0, 1);
    step(1, 1);
    step(0, 0);
    // R6: drive A to the limit and beyond
    for (int i = 0; i < N + 2; i++) step(1, 0);
    // R6: held at the limit, one B brings it to N-1
    step(0, 1);
    step(1, 1);
    step(0, 1);
    for (int i = 0; i < 3; i++) step(0, 0);
    // R7: flag survives until reset
    doReset();
    for (int i = 0; i < N + 3; i++) step(0, 1);
    step(1, 0);
    step(1, 1);
    doReset();
    // mixed phase
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      if (i % 700 == 699) doReset();
      if (r < 3) step(1, 0);
      else if (r < 6) step(0, 1);
      else if (r < 8) step(1, 1);
      else step(0, 0);
    end
    // long one-sided runs inside the mixed phase
    for (int i = 0; i < 2 * N + 2; i++) step(0, 1);
    for (int i = 0; i < 2 * N + 2; i++) step(1, 0);
    step(0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule